// File: doc/BRIEF.md
# Word FIFO Pair with Request Thresholds

This block holds two queues of 32-bit words, eight deep by default, that sit between software and a transfer sequencer. Software loads outgoing words with a push strobe and takes incoming words with a pop strobe. The sequencer drains the outgoing queue and fills the incoming queue over two valid/ready streams. A transfer on either stream happens in a cycle where valid and ready are both high. A stream holding valid low with ready high, or valid high with ready low, is stalled, and the data word must stay stable while it waits. The only exception is a flush, which may withdraw valid or ready for one cycle. Each word carries four bytes.

An 8-bit control word holds one threshold field for each queue and one self-clearing flush command for each queue. An 8-bit status word reports how many outgoing slots are free and how many incoming words are waiting. Two level signals ask an interrupt block for service. The outgoing request is high while enough slots are free, and the incoming request is high while enough words are waiting. A push to a full outgoing queue gives a one-cycle overflow pulse. A pop from an empty incoming queue gives a one-cycle underflow pulse.

Top module: `word_fifo_pair`

## Requirements
- R1: After reset, the status word is 0x80 (8 free, 0 waiting) and the control readback is 0x00. The outgoing request is high, the incoming request is low, tx_out_valid is low and rx_in_ready is high.
- R2: Control word layout: bit 0 flushes the incoming queue and bit 1 flushes the outgoing queue. Bits 4:2 hold the incoming threshold minus one and bits 7:5 hold the outgoing threshold minus one. The two threshold fields read back as written.
- R3: Bits 3:0 of the status word hold the incoming fill count and bits 7:4 hold the outgoing free-slot count. Both counts change in the cycle after each accepted push, pop or stream transfer.
- R4: Words pushed by software leave on the outgoing stream in push order. tx_out_valid is high whenever the queue is non-empty and no flush is pending. A stalled word stays stable.
- R5: The incoming stream accepts words while the queue is not full. rx_in_ready is low when 8 words are held. Software pops return the words in arrival order, and rx_rdata shows the head word.
- R6: tx_data_req is high exactly when the free-slot count is at least the outgoing field value plus one.
- R7: rx_data_req is high exactly when the fill count is at least the incoming field value plus one.
- R8: A push to a full outgoing queue is dropped, the queue contents stay as they were, and tx_overflow is high for the one cycle after that push.
- R9: A pop from an empty incoming queue returns zero on rx_rdata, and rx_underflow is high for the one cycle after that pop.
- R10: Writing a flush bit as 1 makes that bit read back as 1 for exactly one cycle. The matching stream handshake (tx_out_valid or rx_in_ready) is low in that cycle. After it the bit reads 0, the queue is empty, and the other queue is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word value |
| ctrl_rdata | output | 8 | Control readback with live flush bits |
| status_word | output | 8 | Free-slot and fill counts |
| tx_push | input | 1 | Software push into outgoing queue |
| tx_wdata | input | 32 | Word to push |
| rx_pop | input | 1 | Software pop from incoming queue |
| rx_rdata | output | 32 | Incoming head word, zero when empty |
| tx_out_valid | output | 1 | Outgoing stream valid |
| tx_out_ready | input | 1 | Outgoing stream ready from sequencer |
| tx_out_data | output | 32 | Outgoing stream word |
| rx_in_valid | input | 1 | Incoming stream valid from sequencer |
| rx_in_ready | output | 1 | Incoming stream ready |
| rx_in_data | input | 32 | Incoming stream word |
| tx_data_req | output | 1 | Outgoing service request level |
| rx_data_req | output | 1 | Incoming service request level |
| tx_overflow | output | 1 | Dropped-push pulse |
| rx_underflow | output | 1 | Empty-pop pulse |

## Verification
Counts, request levels, stream valid and ready, and the head word all come from registers with only combinational decode after them. Their new values are therefore due in the cycle right after the edge that takes a push, pop, transfer or control write. The overflow and underflow pulses are registered, so each appears in the cycle after the offending strobe and lasts one cycle. A flush bit reads 1 in the cycle after its write and clears one cycle later, and the queue is empty at that point. The bench drives every input on the falling edge and samples shortly after it, so it reads each result exactly one rising edge after its cause. The two scoreboard queues track the expected contents with the same one-edge lag.

// File: rtl/word_fifo_pkg.sv
package word_fifo_pkg;
  localparam int WORD_W     = 32;
  localparam int QUEUE_DEPTH = 8;
  localparam int TRIG_W     = $clog2(QUEUE_DEPTH);
  localparam int COUNT_W    = $clog2(QUEUE_DEPTH + 1);

  // Bit order of this struct is the control word layout, MSB first.
  typedef struct packed {
    logic [TRIG_W-1:0] tx_trig;
    logic [TRIG_W-1:0] rx_trig;
    logic              tx_flush;
    logic              rx_flush;
  } ctrl_word_t;

  localparam int CTRL_W = $bits(ctrl_word_t);
endpackage

// File: rtl/wfp_queue.sv
module wfp_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wipe,
  input  logic                          wr_en,
  input  logic [W-1:0]                  wr_data,
  input  logic                          rd_en,
  output logic [W-1:0]                  rd_data,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          full,
  output logic                          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = wr_en && !full && !wipe;
  assign do_rd   = rd_en && !empty && !wipe;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= step(wp);
      if (do_rd) rp <= step(rp);
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en && !wipe |=> full);
endmodule

// File: rtl/wfp_ctrl.sv
module wfp_ctrl
  import word_fifo_pkg::*;
#(
  parameter int CW = COUNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic              tx_wipe,
  output logic              rx_wipe,
  input  logic [CW-1:0]     tx_free,
  input  logic [CW-1:0]     rx_fill,
  output logic              tx_req,
  output logic              rx_req
);
  ctrl_word_t cfg;
  ctrl_word_t wr_word;

  assign wr_word = ctrl_word_t'(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr) begin
      cfg <= wr_word;
    end else begin
      cfg.tx_flush <= 1'b0;
      cfg.rx_flush <= 1'b0;
    end
  end

  assign rdata   = cfg;
  assign tx_wipe = cfg.tx_flush;
  assign rx_wipe = cfg.rx_flush;

  // Fields hold threshold minus one.
  assign tx_req = (tx_free >= (CW'(cfg.tx_trig) + CW'(1)));
  assign rx_req = (rx_fill >= (CW'(cfg.rx_trig) + CW'(1)));

  // R10
  flush_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.tx_flush || cfg.rx_flush) && !wr |=> !cfg.tx_flush && !cfg.rx_flush);

  // R2
  trig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> cfg.tx_trig == $past(cfg.tx_trig) && cfg.rx_trig == $past(cfg.rx_trig));
endmodule

// File: rtl/word_fifo_pair.sv
module word_fifo_pair
  import word_fifo_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int DEPTH  = QUEUE_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rdata,
  output logic [7:0]        status_word,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              tx_data_req,
  output logic              rx_data_req,
  output logic              tx_overflow,
  output logic              rx_underflow
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          tx_wipe, rx_wipe;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_take, rx_give;
  logic [DATA_W-1:0] rx_head;

  wfp_ctrl #(.CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctrl_wr),
    .wdata   (ctrl_wdata),
    .rdata   (ctrl_rdata),
    .tx_wipe (tx_wipe),
    .rx_wipe (rx_wipe),
    .tx_free (tx_free),
    .rx_fill (rx_cnt),
    .tx_req  (tx_data_req),
    .rx_req  (rx_data_req)
  );

  assign tx_out_valid = !tx_empty && !tx_wipe;
  assign tx_take      = tx_out_valid && tx_out_ready;

  wfp_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (tx_wipe),
    .wr_en   (tx_push),
    .wr_data (tx_wdata),
    .rd_en   (tx_take),
    .rd_data (tx_out_data),
    .count   (tx_cnt),
    .full    (tx_full),
    .empty   (tx_empty)
  );

  assign rx_in_ready = !rx_full && !rx_wipe;
  assign rx_give     = rx_in_valid && rx_in_ready;

  wfp_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (rx_wipe),
    .wr_en   (rx_give),
    .wr_data (rx_in_data),
    .rd_en   (rx_pop),
    .rd_data (rx_head),
    .count   (rx_cnt),
    .full    (rx_full),
    .empty   (rx_empty)
  );

  assign rx_rdata    = rx_empty ? '0 : rx_head;
  assign tx_free     = CW'(DEPTH) - tx_cnt;
  assign status_word = {4'(tx_free), 4'(rx_cnt)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_overflow  <= 1'b0;
      rx_underflow <= 1'b0;
    end else begin
      tx_overflow  <= tx_push && tx_full && !tx_wipe;
      rx_underflow <= rx_pop && rx_empty;
    end
  end

  // R10
  tx_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[1] |=> tx_cnt == '0);

  // R10
  rx_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[0] |=> rx_cnt == '0);

  // R4
  tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready && !(ctrl_wr && ctrl_wdata[1])
      |=> tx_out_valid && $stable(tx_out_data));

  // R5
  rx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && rx_in_ready && !rx_pop |=> rx_cnt == $past(rx_cnt) + CW'(1));

  // R8
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |-> tx_cnt == CW'(DEPTH) || $past(tx_out_valid && tx_out_ready));

  // R9
  udf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && rx_cnt == '0 |-> rx_rdata == '0);
endmodule

// File: tb/tb_word_fifo_pair.sv
module tb_word_fifo_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  ctrl_rdata, status_word;
  logic        tx_push = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        rx_pop = 1'b0;
  logic [31:0] rx_rdata;
  logic        tx_out_valid;
  logic        tx_out_ready = 1'b0;
  logic [31:0] tx_out_data;
  logic        rx_in_valid = 1'b0;
  logic        rx_in_ready;
  logic [31:0] rx_in_data = '0;
  logic        tx_data_req, rx_data_req, tx_overflow, rx_underflow;

  int checks = 0;
  int fails  = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];

  always #5 clk = ~clk;

  word_fifo_pair dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor for the outgoing stream (R4).
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_out_valid && tx_out_ready) begin
      if (txq.size() == 0) check("R4 unexpected word", tx_out_data, 32'hx);
      else check("R4 order", tx_out_data, txq.pop_front());
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic tx_put(input logic [31:0] w);
    bit was_full;
    was_full = (txq.size() == 8);
    @(negedge clk); tx_push = 1'b1; tx_wdata = w;
    @(negedge clk); tx_push = 1'b0;
    if (!was_full) txq.push_back(w);
    check("R8 overflow pulse", 32'(tx_overflow), 32'(was_full));
  endtask

  task automatic rx_send(input logic [31:0] w);
    bit acc;
    @(negedge clk); rx_in_valid = 1'b1; rx_in_data = w;
    #1 acc = rx_in_ready;
    @(negedge clk); rx_in_valid = 1'b0;
    if (acc) rxq.push_back(w);
  endtask

  task automatic rx_get();
    logic [31:0] exp;
    bit was_empty;
    @(negedge clk);
    was_empty = (rxq.size() == 0);
    exp = was_empty ? 32'h0 : rxq[0];
    #1 check(was_empty ? "R9 empty pop data" : "R5 pop order", rx_rdata, exp);
    rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    if (!was_empty) void'(rxq.pop_front());
    check("R9 underflow pulse", 32'(rx_underflow), 32'(was_empty));
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 status", status_word, 8'h80);
    check("R1 ctrl", ctrl_rdata, 8'h00);
    check("R1 txreq", 32'(tx_data_req), 1);
    check("R1 rxreq", 32'(rx_data_req), 0);
    check("R1 valid", 32'(tx_out_valid), 0);
    check("R1 ready", 32'(rx_in_ready), 1);

    // R2: outgoing threshold 4
    wr_ctrl(8'h60);
    check("R2 readback", ctrl_rdata, 8'h60);

    for (int i = 0; i < 8; i++) begin
      tx_put(32'hA000_0000 + 32'(i));
      check("R3 tx free", 32'(status_word[7:4]), 32'(8 - txq.size()));
      check("R6 txreq", 32'(tx_data_req), 32'((8 - txq.size()) >= 4));
    end
    check("R4 valid when nonempty", 32'(tx_out_valid), 1);
    tx_put(32'hDEAD_BEEF);  // R8 dropped
    check("R8 status", status_word, 8'h00);

    tx_out_ready = 1'b1;
    for (int k = 0; k < 40 && txq.size() != 0; k++) @(negedge clk);
    @(negedge clk);
    tx_out_ready = 1'b0;
    check("R4 drained", status_word, 8'h80);
    check("R4 valid low", 32'(tx_out_valid), 0);

    // R7: incoming threshold 3
    wr_ctrl(8'h08);
    check("R2 readback rx", ctrl_rdata, 8'h08);
    for (int i = 0; i < 9; i++) begin
      rx_send(32'h5500_0000 + 32'(i));
      check("R3 rx fill", 32'(status_word[3:0]), 32'(rxq.size()));
      check("R7 rxreq", 32'(rx_data_req), 32'(rxq.size() >= 3));
    end
    check("R5 ready low when full", 32'(rx_in_ready), 0);
    check("R5 full status", status_word, 8'h88);
    for (int i = 0; i < 8; i++) rx_get();
    rx_get();  // R9 pop from empty
    check("R9 status", status_word, 8'h80);

    // R10 flush outgoing, incoming kept
    for (int i = 0; i < 3; i++) tx_put(32'hC000_0000 + 32'(i));
    for (int i = 0; i < 2; i++) rx_send(32'hE000_0000 + 32'(i));
    wr_ctrl(8'h0A);
    check("R10 tx flush bit set", ctrl_rdata, 8'h0A);
    check("R10 valid low in flush", 32'(tx_out_valid), 0);
    @(negedge clk);
    txq.delete();
    check("R10 tx flush bit clear", ctrl_rdata, 8'h08);
    check("R10 tx empty rx kept", status_word, 8'h82);

    wr_ctrl(8'h09);
    check("R10 rx flush bit set", ctrl_rdata, 8'h09);
    check("R10 ready low in flush", 32'(rx_in_ready), 0);
    @(negedge clk);
    rxq.delete();
    check("R10 rx flush bit clear", ctrl_rdata, 8'h08);
    check("R10 rx empty", status_word, 8'h80);
    check("R10 rxreq low", 32'(rx_data_req), 0);
    rx_get();

    // R4 order after flush
    tx_put(32'h1234_5678);
    tx_out_ready = 1'b1;
    repeat (3) @(negedge clk);
    tx_out_ready = 1'b0;
    check("R4 queue consumed", 32'(txq.size()), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule